// File: doc/BRIEF.md
# Up/Down External Event Counter

This block counts transitions on an asynchronous event input with a 16-bit counter. The counter can count up or down. An 8-bit mode register sets four things: which edge of the input is counted, whether the count direction comes from a software-written bit or from the level on a pin, what happens when the count passes its end value, and whether the block drives a pulse output on the shared direction/output pin.

Software uses a single write port. A select field chooses one of four targets: the mode register, the reload value, the direction bit or the run bit. The live count is always visible on `count_q`. Every wrap of the counter, in either direction, raises `wrap_irq` for one clock. When pulse output is enabled and the shared pin is not used for direction, each wrap also toggles `pulse_out`.

Top module: `evt_updown_cnt`

## Requirements
- R1: After a synchronous active-low reset, `count_q` is 0, `wrap_irq` is 0, `pulse_out` is 0 and `pulse_oe` is 0. The mode register is 0x00, so the block does not count.
- R2: The counter changes on an event only when two conditions hold: the run bit (written with `wr_sel`=3, `wr_data[0]`) is 1, and mode bits [1:0] equal 2'b01. In any other mode or while stopped, events leave `count_q` unchanged.
- R3: Mode bit 5 selects the counted edge of `evt_in`: 0 counts falling edges and 1 counts rising edges. Each counted edge changes the count by exactly one, and the other edge changes nothing.
- R4: Mode bit 4 selects where the direction comes from. When it is 0, the direction bit (written with `wr_sel`=2, `wr_data[0]`) is used: 1 counts up and 0 counts down. When it is 1, the level on `dir_pin_in` is used: high counts up and low counts down.
- R5: When mode bit 6 is 0 (reload type), counting down from 0 or counting up from 0xFFFF loads the count from the reload register (written with `wr_sel`=1).
- R6: When mode bit 6 is 1 (free-run type), the count wraps modulo 2^16: up from 0xFFFF gives 0, and down from 0 gives 0xFFFF.
- R7: Every wrap, whether an overflow or an underflow, sets `wrap_irq` high for exactly one clock. `wrap_irq` rises in the same cycle that `count_q` shows the wrapped value.
- R8: `pulse_oe` is 1 exactly when mode bit 2 is 1 and mode bit 4 is 0. While `pulse_oe` is 1, `pulse_out` toggles on each wrap. At all other times `pulse_out` holds its value.
- R9: A write to the reload register while the run bit is 0 also loads `count_q` with the written value. While the run bit is 1, such a write leaves `count_q` unchanged.
- R10: A change on `evt_in` that is counted shows on `count_q` after the third rising clock edge that follows it, and not before.
- R11: Mode bit 3 is reserved and has no effect on counting, direction or the pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 reload, 2 direction bit, 3 run bit |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | Asynchronous external event input |
| dir_pin_in | input | 1 | Level of the shared direction/output pin |
| count_q | output | 16 | Current count |
| wrap_irq | output | 1 | One-cycle overflow/underflow flag |
| pulse_out | output | 1 | Toggling pulse output value |
| pulse_oe | output | 1 | Output enable for the shared pin |

## Verification
Faults inside the block show at the ports within a few cycles. If the synchronizer or the edge state is wrong, a counted edge is missed or counted twice, and `count_q` is off by one three clocks after the input changes. If the direction or wrap selection is wrong, the next count is wrong or goes the wrong way, and the error shows on the first wrap through the end value as a wrong value or a missing `wrap_irq`. A wrong pulse toggle state stays on `pulse_out` until the next wrap. The bench predicts each of these values from the written configuration and samples them in the exact cycle each one should appear.

// File: rtl/evc_pkg.sv
// Shared types and field positions for the up/down event counter.
// Assumes the written mode byte sits in the low eight bits of the write data.
package evc_pkg;

    localparam int MODE_W = 8;

    // Bit positions within the written mode byte
    localparam int BIT_PULSE = 2;
    localparam int BIT_RSVD  = 3;
    localparam int BIT_DSRC  = 4;
    localparam int BIT_RISE  = 5;
    localparam int BIT_FREE  = 6;

    // Operation-mode field value that enables event counting
    localparam logic [1:0] OP_EVENT = 2'b01;

    // Write-port targets
    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_DIR    = 2'd2,
        SEL_RUN    = 2'd3
    } wsel_e;

    // Decoded mode: only the fields the hardware acts on are stored
    typedef struct packed {
        logic       free_run;
        logic       edge_rise;
        logic       dir_from_pin;
        logic       pulse_en;
        logic [1:0] op_mode;
    } mode_t;

endpackage

// File: rtl/evc_edge_sync.sv
// Synchronizes an asynchronous event input and detects one selected edge.
// Produces a one-clock pulse per selected edge of the synchronized signal.
// Assumes SYNC_STAGES >= 2 and that the input stays stable for at least two
// clocks between edges.
module evc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic edge_rise,
    output logic evt_pulse
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_chain;
    logic                   prev_lvl;
    logic                   cur_lvl;

    // Synchronizer shift chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_chain <= '0;
            prev_lvl   <= 1'b0;
        end else begin
            sync_chain <= {sync_chain[TOP-1:0], async_in};
            prev_lvl   <= sync_chain[TOP];
        end
    end

    assign cur_lvl = sync_chain[TOP];

    // Select rising or falling transition of the synchronized level
    always_comb begin
        if (edge_rise) begin
            evt_pulse = cur_lvl & ~prev_lvl;
        end else begin
            evt_pulse = ~cur_lvl & prev_lvl;
        end
    end

endmodule

// File: rtl/evc_cfg_regs.sv
// Holds the mode fields, the reload value, the direction bit and the run bit.
// Flags a reload write made while stopped so the counter can take the value.
// Assumes CNT_W >= MODE_W.
module evc_cfg_regs
    import evc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output mode_t            mode_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             dir_bit_q,
    output logic             run_q,
    output logic             load_now
);

    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    // Register updates from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            reload_q  <= '0;
            dir_bit_q <= 1'b0;
            run_q     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: begin
                    mode_q.op_mode      <= wr_data[1:0];
                    mode_q.pulse_en     <= wr_data[BIT_PULSE];
                    mode_q.dir_from_pin <= wr_data[BIT_DSRC];
                    mode_q.edge_rise    <= wr_data[BIT_RISE];
                    mode_q.free_run     <= wr_data[BIT_FREE];
                end
                SEL_RELOAD: reload_q  <= wr_data;
                SEL_DIR:    dir_bit_q <= wr_data[0];
                SEL_RUN:    run_q     <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // A reload write while stopped also loads the counter
    assign load_now = wr_en && (sel == SEL_RELOAD) && !run_q;

endmodule

// File: rtl/evc_count_core.sv
// Up/down counter with a reload-or-wrap choice at both ends. Drives a
// one-cycle wrap flag and a toggle flop for the pulse output.
// Assumes step_en and load_en are never high in the same cycle.
module evc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             count_up,
    input  logic             free_run,
    input  logic             toggle_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             wrap_q,
    output logic             pulse_q
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ZERO     = '0;
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             at_top;
    logic             at_bot;
    logic             wrap_now;
    logic [CNT_W-1:0] next_step;

    // Next value for one counted event, including end-of-range handling
    always_comb begin
        at_top = (count_q == ALL_ONES);
        at_bot = (count_q == ZERO);
        if (count_up) begin
            wrap_now  = at_top;
            next_step = at_top ? (free_run ? ZERO : reload_val) : count_q + ONE;
        end else begin
            wrap_now  = at_bot;
            next_step = at_bot ? (free_run ? ALL_ONES : reload_val) : count_q - ONE;
        end
    end

    // Count register: software load when stopped, else step on an event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (step_en) begin
            count_q <= next_step;
        end
    end

    // Wrap flag and pulse toggle, aligned with the wrapped count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            wrap_q  <= step_en & wrap_now;
            pulse_q <= pulse_q ^ (step_en & wrap_now & toggle_en);
        end
    end

endmodule

// File: rtl/evt_updown_cnt.sv
// Top of the up/down external event counter. Combines the configuration
// registers, the event synchronizer and the counter core. The direction
// comes from a register bit or from the shared pin. The pulse output drives
// that pin only when the pin is not used for direction.
module evt_updown_cnt
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             evt_in,
    input  logic             dir_pin_in,
    output logic [CNT_W-1:0] count_q,
    output logic             wrap_irq,
    output logic             pulse_out,
    output logic             pulse_oe
);

    mode_t            mode_q;
    logic [CNT_W-1:0] reload_q;
    logic             dir_bit_q;
    logic             run_q;
    logic             reload_load;
    logic             evt_pulse;
    logic             run_cnt;
    logic             step_en;
    logic             count_up;
    logic             dir_src;

    evc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mode_q    (mode_q),
        .reload_q  (reload_q),
        .dir_bit_q (dir_bit_q),
        .run_q     (run_q),
        .load_now  (reload_load)
    );

    evc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (evt_in),
        .edge_rise (mode_q.edge_rise),
        .evt_pulse (evt_pulse)
    );

    // Counting is allowed only in event mode with the run bit set
    assign run_cnt  = run_q && (mode_q.op_mode == OP_EVENT);
    assign step_en  = run_cnt && evt_pulse;
    // Direction from pin level or register bit, sampled with the event
    assign dir_src  = mode_q.dir_from_pin;
    assign count_up = dir_src ? dir_pin_in : dir_bit_q;
    // The pin is driven only when it is not the direction input
    assign pulse_oe = mode_q.pulse_en && !dir_src;

    evc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .count_up   (count_up),
        .free_run   (mode_q.free_run),
        .toggle_en  (pulse_oe),
        .load_en    (reload_load),
        .load_val   (wr_data),
        .reload_val (reload_q),
        .count_q    (count_q),
        .wrap_q     (wrap_irq),
        .pulse_q    (pulse_out)
    );

endmodule

// File: rtl/evc_checks.sv
// Temporal checks for the event counter, attached to the top by bind.
module evc_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_q,
    input logic             wrap_irq,
    input logic             pulse_out,
    input logic             pulse_oe,
    input logic             run_cnt,
    input logic             load_en,
    input logic             dir_src
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic past_ok;

    // Marks that at least one post-reset cycle has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |=> !wrap_irq);

    // R8
    pin_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_src |-> !pulse_oe);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(run_cnt) && !$past(load_en)) |-> $stable(count_q));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !wrap_irq && !$past(load_en) && (count_q != $past(count_q)))
        |-> ((count_q == $past(count_q) + ONE) || (count_q == $past(count_q) - ONE)));

    // R8
    pulse_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !wrap_irq) |-> $stable(pulse_out));

endmodule

bind evt_updown_cnt evc_checks #(.CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_q   (count_q),
    .wrap_irq  (wrap_irq),
    .pulse_out (pulse_out),
    .pulse_oe  (pulse_oe),
    .run_cnt   (run_cnt),
    .load_en   (reload_load),
    .dir_src   (dir_src)
);

// File: tb/evt_updown_cnt_bench.sv
// Scoreboard bench: driver tasks update a requirement model and queue
// expectations; a monitor pops one per falling edge and compares.
module evt_updown_cnt_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         evt_in = 1'b0;
    logic         dir_pin_in = 1'b0;
    wire  [W-1:0] count_q;
    wire          wrap_irq;
    wire          pulse_out;
    wire          pulse_oe;

    always #10 clk = ~clk;

    evt_updown_cnt u_evt_updown_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .evt_in     (evt_in),
        .dir_pin_in (dir_pin_in),
        .count_q    (count_q),
        .wrap_irq   (wrap_irq),
        .pulse_out  (pulse_out),
        .pulse_oe   (pulse_oe)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] cnt;
        logic         irq;
        logic         pout;
        logic         poe;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Requirement model
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_reload = '0;
    logic [7:0]   m_mode = '0;
    logic         m_dir = 1'b0;
    logic         m_run = 1'b0;
    logic         m_pout = 1'b0;

    function automatic logic m_poe();
        return m_mode[2] & ~m_mode[4];
    endfunction

    task automatic push(input string tag, input logic irq);
        exp_t e;
        e.tag = tag; e.cnt = m_cnt; e.irq = irq; e.pout = m_pout; e.poe = m_poe();
        sb.push_back(e);
    endtask

    // Apply one counted event to the model; returns 1 on a wrap
    function automatic logic m_step();
        logic up;
        logic w;
        w = 1'b0;
        if (!(m_run && m_mode[1:0] == 2'b01)) return 1'b0;
        up = m_mode[4] ? dir_pin_in : m_dir;
        if (up) begin
            if (m_cnt == 16'hFFFF) begin
                w = 1'b1;
                m_cnt = m_mode[6] ? 16'h0000 : m_reload;
            end else m_cnt = m_cnt + 16'd1;
        end else begin
            if (m_cnt == 16'h0000) begin
                w = 1'b1;
                m_cnt = m_mode[6] ? 16'hFFFF : m_reload;
            end else m_cnt = m_cnt - 16'd1;
        end
        if (w && m_poe()) m_pout = ~m_pout;
        return w;
    endfunction

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (count_q !== e.cnt || wrap_irq !== e.irq || pulse_out !== e.pout || pulse_oe !== e.poe) begin
                errors++;
                $display("FAIL %s: count=%h irq=%b pout=%b poe=%b expected count=%h irq=%b pout=%b poe=%b",
                         e.tag, count_q, wrap_irq, pulse_out, pulse_oe, e.cnt, e.irq, e.pout, e.poe);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (s)
            2'd0: m_mode = d[7:0];
            2'd1: begin m_reload = d; if (!m_run) m_cnt = d; end
            2'd2: m_dir = d[0];
            default: m_run = d[0];
        endcase
    endtask

    // Drive evt_in to lvl; expect the result after the third rising edge
    task automatic drive_evt(input logic lvl, input string tag, input bit lat_chk);
        logic counted;
        logic w;
        @(negedge clk);
        evt_in = lvl;
        counted = (lvl == m_mode[5]);
        repeat (2) @(posedge clk);
        if (lat_chk) begin
            @(negedge clk);
            push({tag, " before third edge"}, 1'b0);
        end
        @(posedge clk);
        w = counted ? m_step() : 1'b0;
        @(negedge clk);
        push(tag, w);
        if (w) begin
            @(negedge clk);
            push({tag, " R7 flag clears"}, 1'b0);
        end
    endtask

    // One counted edge, preceded by the other edge when needed
    task automatic count_one(input string tag);
        logic target;
        target = m_mode[5];
        if (evt_in == target) drive_evt(~target, {tag, " R3 other edge ignored"}, 1'b0);
        drive_evt(target, tag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset state", 1'b0);

        wr(2'd3, 16'h0001);
        wr(2'd2, 16'h0001);
        count_one("R2 mode 00 no count");

        wr(2'd0, 16'h0021);
        count_one("R3 rising counted");
        count_one("R3 rising counted again");
        drive_evt(1'b0, "R10 prep", 1'b0);
        drive_evt(1'b1, "R10 latency", 1'b1);

        wr(2'd0, 16'h0001);
        count_one("R3 falling counted");

        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0010);
        @(negedge clk);
        push("R9 reload write while running", 1'b0);
        for (int i = 0; i < 4; i++) count_one("R4 register bit down");
        count_one("R5 underflow reloads");

        wr(2'd3, 16'h0000);
        wr(2'd1, 16'hFFFE);
        @(negedge clk);
        push("R9 reload write while stopped", 1'b0);
        count_one("R2 stopped no count");
        wr(2'd3, 16'h0001);
        wr(2'd2, 16'h0001);
        count_one("R4 register bit up");
        count_one("R5 overflow reloads");

        wr(2'd0, 16'h0041);
        count_one("R6 free-run up");
        count_one("R6 up wrap to zero");
        wr(2'd2, 16'h0000);
        count_one("R6 down wrap to max");

        wr(2'd0, 16'h0051);
        dir_pin_in = 1'b1;
        count_one("R4 pin high counts up");
        dir_pin_in = 1'b0;
        count_one("R4 pin low counts down");
        count_one("R4 pin low again");
        dir_pin_in = 1'b1;
        wr(2'd0, 16'h0041);
        count_one("R4 pin ignored with register source");

        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0001);
        wr(2'd3, 16'h0001);
        wr(2'd0, 16'h0045);
        @(negedge clk);
        push("R8 output enabled", 1'b0);
        count_one("R8 count to zero");
        count_one("R8 toggle on wrap");
        wr(2'd0, 16'h0055);
        @(negedge clk);
        push("R8 output disabled with pin direction", 1'b0);
        dir_pin_in = 1'b0;
        count_one("R8 pin direction down");

        wr(2'd0, 16'h004D);
        count_one("R11 reserved bit set");

        wr(2'd0, 16'h0047);
        count_one("R2 mode 11 no count");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule